// File: doc/BRIEF.md
# SPI Command Frame Builder with CRC-7

This block assembles a single command frame for a host-side SPI master and hands it, one byte at a time, to a byte-wide SPI PHY. The host presents an opcode together with an address, a data word, a transfer size, a clockless flag and a CRC-enable flag, then pulses `start`. The opcode decides which of the address, size and data fields go into the frame and how many bytes each takes. Every multi-byte field goes out most significant byte first.

When CRC is enabled, one extra byte closes the frame. It carries a 7-bit CRC over every byte that came before it. The CRC uses the polynomial x^7 + x^3 + 1 and is seeded with all ones. It sits in bits 7:1 of that byte, and bit 0 is zero. When CRC is disabled, the frame ends after the last field byte.

The PHY takes bytes through a valid/ready handshake. `busy` covers the whole frame, and `done` pulses once after the PHY accepts the final byte. Chip select, clock generation, response parsing and the data phases belong to other blocks.

Top module: `spi_cmd_framer`

## Requirements
- R1: The first byte of every frame is the opcode. The cycle after an accepted `start`, `busy` and `tx_valid` are high and `tx_byte` equals the opcode that was sampled.
- R2: Opcodes 0xC1 and 0xC2 send the opcode, then address bits 23:16, 15:8 and 7:0, then size bits 15:8 and 7:0. That is 6 bytes before the CRC.
- R3: Opcodes 0xC7 and 0xC8 send the opcode, three address bytes (high first), then size bits 23:16, 15:8 and 7:0. That is 7 bytes before the CRC.
- R4: Opcode 0xC3 sends the opcode, address bits 15:8, address bits 7:0, then four data bytes (bits 31:24 first). In the first address byte, bit 7 is forced to 1 when `clockless` is high; otherwise it carries address bit 15.
- R5: Opcode 0xC4 sends the opcode, address bits 15:8 (with the same `clockless` rule on bit 7), address bits 7:0, and one zero byte. That is 4 bytes.
- R6: Opcode 0xC9 sends the opcode, three address bytes and four data bytes, 8 bytes in all. Opcode 0xCA sends the opcode and three address bytes, 4 bytes in all.
- R7: Opcodes 0xC5, 0xC6 and 0xCF send the opcode followed by three zero bytes. `clockless` affects only opcodes 0xC3 and 0xC4.
- R8: With `crc_en` high, one more byte follows the field bytes. Its bits 7:1 hold the CRC-7 (polynomial 0x09, seed 0x7F) of all earlier frame bytes, each processed MSB first, and its bit 0 is 0.
- R9: With `crc_en` low, no CRC byte is sent, and the frame ends after the last field byte.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_byte` and `tx_valid` hold their values into the next cycle.
- R11: A `start` that arrives while `busy` is high, or that carries an opcode not listed in R2 to R7, is ignored. No byte is emitted for it, and the frame in flight is unchanged.
- R12: `done` is high for exactly one cycle: the cycle after the handshake on the final byte. In that same cycle `busy` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to build and send one frame |
| opcode | input | 8 | Command opcode |
| addr | input | 24 | Target address |
| wdata | input | 32 | Data word for write commands |
| xfer_size | input | 24 | Transfer size for block commands |
| clockless | input | 1 | Marks an internal access as clockless |
| crc_en | input | 1 | Append the CRC byte |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| tx_byte | output | 8 | Byte offered to the PHY |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_ready | input | 1 | PHY accepts `tx_byte` this cycle |

## Verification
Two things can happen on the same clock edge. First, when the last field byte is handshaked, the CRC accumulator absorbs that byte on the same edge where the sequencer moves on to the CRC byte. Second, a fresh `start` can arrive while a frame is still being sent. The sweep exercises the first case by running every opcode with and without CRC under three ready patterns, some of which stall exactly at the field-to-CRC boundary. The bench then compares each CRC byte against a bitwise CRC computed independently. For the second case, the bench raises `start` with a different opcode in the middle of a stalled frame. It then requires the original byte stream to come out intact, and requires `busy` to stay low after `done`.

// File: rtl/spi_cmd_framer_pkg.sv
package spi_cmd_framer_pkg;

    parameter int BYTE_W = 8;
    parameter int ADDR_W = 24;
    parameter int DATA_W = 32;
    parameter int SIZE_W = 24;
    parameter int CRC_W  = 7;

    // Longest field section: opcode + full address + full data word
    localparam int MAX_BODY  = 1 + ADDR_W / BYTE_W + DATA_W / BYTE_W;
    localparam int FRAME_MAX = MAX_BODY + 1;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int BODY_IW   = $clog2(MAX_BODY);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CRC_W-1:0]  crc_t;

    typedef enum byte_t {
        OP_BLK_WR     = 8'hC1,
        OP_BLK_RD     = 8'hC2,
        OP_REG_WR     = 8'hC3,
        OP_REG_RD     = 8'hC4,
        OP_STOP       = 8'hC5,
        OP_AGAIN      = 8'hC6,
        OP_BLK_WR_EXT = 8'hC7,
        OP_BLK_RD_EXT = 8'hC8,
        OP_WORD_WR    = 8'hC9,
        OP_WORD_RD    = 8'hCA,
        OP_RESTART    = 8'hCF
    } opcode_e;

    typedef struct packed {
        logic                      known;
        logic [LEN_W-1:0]          len;
        byte_t [MAX_BODY-1:0]      body;
    } frame_t;

    localparam crc_t CRC_SEED = 7'h7F;
    localparam crc_t CRC_POLY = 7'h09;

    // One byte of CRC-7: fold the running value into the byte, then divide
    function automatic crc_t crc7_step(input crc_t crc, input byte_t din);
        byte_t v;
        crc_t  r;
        logic  fb;
        v = {crc, 1'b0} ^ din;
        r = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ v[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_cmd_layout.sv
module spi_cmd_layout
    import spi_cmd_framer_pkg::*;
(
    input  byte_t               opcode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [SIZE_W-1:0]   xfer_size,
    input  logic                clockless,
    output frame_t              frm
);

    byte_t reg_hi;

    always_comb begin
        reg_hi = addr[15:8] | {clockless, 7'b0};
        frm         = '0;
        frm.known   = 1'b1;
        frm.body[0] = opcode;
        case (opcode)
            OP_BLK_WR, OP_BLK_RD: begin
                frm.len     = LEN_W'(6);
                frm.body[1] = addr[23:16];
                frm.body[2] = addr[15:8];
                frm.body[3] = addr[7:0];
                frm.body[4] = xfer_size[15:8];
                frm.body[5] = xfer_size[7:0];
            end
            OP_BLK_WR_EXT, OP_BLK_RD_EXT: begin
                frm.len     = LEN_W'(7);
                frm.body[1] = addr[23:16];
                frm.body[2] = addr[15:8];
                frm.body[3] = addr[7:0];
                frm.body[4] = xfer_size[23:16];
                frm.body[5] = xfer_size[15:8];
                frm.body[6] = xfer_size[7:0];
            end
            OP_REG_WR: begin
                frm.len     = LEN_W'(7);
                frm.body[1] = reg_hi;
                frm.body[2] = addr[7:0];
                frm.body[3] = wdata[31:24];
                frm.body[4] = wdata[23:16];
                frm.body[5] = wdata[15:8];
                frm.body[6] = wdata[7:0];
            end
            OP_REG_RD: begin
                frm.len     = LEN_W'(4);
                frm.body[1] = reg_hi;
                frm.body[2] = addr[7:0];
            end
            OP_WORD_WR: begin
                frm.len     = LEN_W'(8);
                frm.body[1] = addr[23:16];
                frm.body[2] = addr[15:8];
                frm.body[3] = addr[7:0];
                frm.body[4] = wdata[31:24];
                frm.body[5] = wdata[23:16];
                frm.body[6] = wdata[15:8];
                frm.body[7] = wdata[7:0];
            end
            OP_WORD_RD: begin
                frm.len     = LEN_W'(4);
                frm.body[1] = addr[23:16];
                frm.body[2] = addr[15:8];
                frm.body[3] = addr[7:0];
            end
            OP_STOP, OP_AGAIN, OP_RESTART: begin
                frm.len     = LEN_W'(4);
            end
            default: begin
                frm.known   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spi_crc7_acc.sv
module spi_crc7_acc
    import spi_cmd_framer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  en,
    input  byte_t din,
    output crc_t  crc
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc <= CRC_SEED;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end

endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
    import spi_cmd_framer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [7:0]         opcode,
    input  logic [23:0]        addr,
    input  logic [31:0]        wdata,
    input  logic [23:0]        xfer_size,
    input  logic               clockless,
    input  logic               crc_en,
    output logic               busy,
    output logic               done,
    output logic [7:0]         tx_byte,
    output logic               tx_valid,
    input  logic               tx_ready
);

    frame_t            frm_d;
    frame_t            frm_q;
    logic              crc_on_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  total;
    logic              busy_q;
    logic              done_q;
    logic              accept;
    logic              hs;
    logic              in_body;
    logic              last;
    byte_t             body_byte;
    crc_t              crc_val;

    spi_cmd_layout u_layout (
        .opcode    (opcode),
        .addr      (addr),
        .wdata     (wdata),
        .xfer_size (xfer_size),
        .clockless (clockless),
        .frm       (frm_d)
    );

    assign accept    = start && !busy_q && frm_d.known;
    assign hs        = busy_q && tx_ready;
    assign total     = frm_q.len + LEN_W'(crc_on_q);
    assign in_body   = idx_q < frm_q.len;
    assign last      = idx_q == total - LEN_W'(1);
    assign body_byte = frm_q.body[idx_q[BODY_IW-1:0]];

    spi_crc7_acc u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .en    (hs && in_body),
        .din   (body_byte),
        .crc   (crc_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q    <= '0;
            crc_on_q <= 1'b0;
            idx_q    <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                frm_q    <= frm_d;
                crc_on_q <= crc_en;
                idx_q    <= '0;
                busy_q   <= 1'b1;
            end else if (hs) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + LEN_W'(1);
                end
            end
        end
    end

    assign tx_byte  = in_body ? body_byte : {crc_val, 1'b0};
    assign tx_valid = busy_q;
    assign busy     = busy_q;
    assign done     = done_q;

endmodule

// File: rtl/spi_cmd_framer_chk.sv
module spi_cmd_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [7:0] opcode,
    input logic       busy,
    input logic       done,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_byte
);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    p_busy_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !tx_ready) |=> busy);

    p_first_byte_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (tx_byte == $past(opcode)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !tx_valid && $past(tx_valid && tx_ready)));

    p_start_blocked_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !tx_ready) |=> (busy && $stable(tx_byte)));

endmodule

bind spi_cmd_framer spi_cmd_framer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .opcode   (opcode),
    .busy     (busy),
    .done     (done),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_byte  (tx_byte)
);

// File: tb/spi_cmd_framer_tb_top.sv
module spi_cmd_framer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [23:0] xfer_size = '0;
    logic        clockless = 1'b0;
    logic        crc_en = 1'b0;
    logic        tx_ready = 1'b0;
    logic        busy, done, tx_valid;
    logic [7:0]  tx_byte;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] exp_b [0:8];
    int         exp_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_cmd_framer dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .addr(addr),
        .wdata(wdata), .xfer_size(xfer_size), .clockless(clockless),
        .crc_en(crc_en), .busy(busy), .done(done), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic string op_tag(input logic [7:0] op);
        case (op)
            8'hC1, 8'hC2: return "R2";
            8'hC7, 8'hC8: return "R3";
            8'hC3:        return "R4";
            8'hC4:        return "R5";
            8'hC9, 8'hCA: return "R6";
            default:      return "R7";
        endcase
    endfunction

    // Expected frame built from the requirement text
    task automatic make_expected(input logic [7:0] op, input logic [23:0] a,
                                 input logic [31:0] d, input logic [23:0] s,
                                 input logic cl, input logic ce);
        logic [7:0] hi;
        logic [6:0] r;
        logic       top;
        hi = {a[15] | cl, a[14:8]};
        for (int k = 0; k < 9; k++) exp_b[k] = 8'h00;
        exp_b[0] = op;
        case (op)
            8'hC1, 8'hC2: begin
                exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
                exp_b[4] = s[15:8];  exp_b[5] = s[7:0];  exp_n = 6;
            end
            8'hC7, 8'hC8: begin
                exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
                exp_b[4] = s[23:16]; exp_b[5] = s[15:8]; exp_b[6] = s[7:0];
                exp_n = 7;
            end
            8'hC3: begin
                exp_b[1] = hi; exp_b[2] = a[7:0];
                exp_b[3] = d[31:24]; exp_b[4] = d[23:16];
                exp_b[5] = d[15:8];  exp_b[6] = d[7:0]; exp_n = 7;
            end
            8'hC4: begin
                exp_b[1] = hi; exp_b[2] = a[7:0]; exp_n = 4;
            end
            8'hC9: begin
                exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
                exp_b[4] = d[31:24]; exp_b[5] = d[23:16];
                exp_b[6] = d[15:8];  exp_b[7] = d[7:0]; exp_n = 8;
            end
            8'hCA: begin
                exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
                exp_n = 4;
            end
            default: exp_n = 4;
        endcase
        if (ce) begin
            r = 7'h7F;
            for (int k = 0; k < exp_n; k++) begin
                for (int b = 7; b >= 0; b--) begin
                    top = r[6] ^ exp_b[k][b];
                    r = {r[5:0], 1'b0};
                    if (top) r = r ^ 7'h09;
                end
            end
            exp_b[exp_n] = {r, 1'b0};
            exp_n++;
        end
    endtask

    function automatic logic ready_pat(input int cyc, input int pat);
        case (pat)
            0:       return 1'b1;
            1:       return (cyc % 3) != 2;
            default: return cyc[0];
        endcase
    endfunction

    task automatic run_frame(input logic [7:0] op, input logic [23:0] a,
                             input logic [31:0] d, input logic [23:0] s,
                             input logic cl, input logic ce, input int pat,
                             input bit inject);
        int         got;
        int         cyc;
        bit         stalled;
        logic [7:0] prev;
        string      tag;
        make_expected(op, a, d, s, cl, ce);
        @(negedge clk);
        opcode = op; addr = a; wdata = d; xfer_size = s;
        clockless = cl; crc_en = ce; start = 1'b1; tx_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && tx_valid === 1'b1, "R12 busy after start", busy, 1);
        got = 0; cyc = 0; stalled = 1'b0; prev = 8'h00;
        while (got < exp_n && cyc < 100) begin
            if (inject && cyc < 3) begin
                tx_ready = 1'b0;
                start = (cyc == 1);
                if (cyc == 1) begin
                    opcode = 8'hC5; addr = 24'h0;
                end
            end else begin
                start = 1'b0;
                tx_ready = ready_pat(cyc, pat);
            end
            if (stalled)
                check(tx_valid === 1'b1 && tx_byte === prev,
                      "R10 hold under stall", tx_byte, prev);
            if (tx_valid && tx_ready) begin
                if (got == 0) tag = "R1";
                else if (ce && got == exp_n - 1) tag = "R8";
                else tag = op_tag(op);
                if (inject) tag = {tag, " R11"};
                check(tx_byte === exp_b[got], tag, tx_byte, exp_b[got]);
                got++;
            end
            stalled = tx_valid && !tx_ready;
            prev = tx_byte;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        tx_ready = 1'b0;
        check(got == exp_n, "R12 byte count", got, exp_n);
        check(done === 1'b1 && busy === 1'b0 && tx_valid === 1'b0,
              ce ? "R12 done after last byte" : "R9 done without CRC byte",
              {done, busy}, 2'b10);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0,
              inject ? "R11 no queued frame" : "R12 done single pulse",
              {done, busy}, 0);
    endtask

    logic [7:0]  ops   [0:10] = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6,
                                  8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCF};
    logic [7:0]  bad   [0:7]  = '{8'h00, 8'hC0, 8'hCB, 8'hCC, 8'hCD, 8'hCE,
                                  8'hD0, 8'hFF};
    logic [23:0] avec  [0:3]  = '{24'h123456, 24'hFFFFFF, 24'h00807F, 24'hA5C3E1};
    logic [31:0] dvec  [0:3]  = '{32'hDEADBEEF, 32'h00000000, 32'hFFFFFFFF, 32'h80010203};
    logic [23:0] svec  [0:3]  = '{24'h000100, 24'hFFFFFF, 24'h012345, 24'h7F8000};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && tx_valid === 1'b0,
              "R12 reset state", {busy, done, tx_valid}, 0);

        // Unlisted opcodes must not start a frame
        for (int i = 0; i < 8; i++) begin
            opcode = bad[i]; crc_en = 1'b1; start = 1'b1; tx_ready = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b0 && tx_valid === 1'b0, "R11 unknown opcode",
                  {busy, tx_valid}, 0);
            @(negedge clk);
            check(busy === 1'b0 && done === 1'b0, "R11 unknown opcode idle",
                  {busy, done}, 0);
        end

        // Sweep all opcodes, CRC on/off, clockless on/off, four field sets
        for (int o = 0; o < 11; o++)
            for (int ce = 0; ce < 2; ce++)
                for (int cl = 0; cl < 2; cl++)
                    for (int v = 0; v < 4; v++)
                        run_frame(ops[o], avec[v], dvec[v], svec[v],
                                  cl[0], ce[0], (v + o) % 3, 1'b0);

        // Start arriving mid-frame is dropped
        run_frame(8'hCA, 24'h123456, 32'h0, 24'h0, 1'b0, 1'b1, 0, 1'b1);
        run_frame(8'hC9, 24'hABCDEF, 32'h01020304, 24'h0, 1'b1, 1'b0, 1, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule